// File: doc/BRIEF.md
# VSYNC filter and field detector

This block sits in the pixel clock domain behind a video receiver. It cleans up the incoming horizontal and vertical sync and drives new versions of both. It takes HSYNC, VSYNC and a pixel clock enable. All of its state advances only on cycles where the enable is high, which are called pixel steps below. It measures the line period between HSYNC leading edges. It rejects VSYNC pulses shorter than one line. It re-times each accepted VSYNC so that its output edges fall in the middle of a line, well away from any HSYNC leading edge, which makes the first line of every frame unambiguous.

For each accepted VSYNC the block records where the VSYNC leading edge fell within its line and uses that position to set an odd/even field flag. It also latches the number of HSYNC leading edges seen since the previous accepted VSYNC. The output HSYNC is regenerated with a programmable width in pixel steps, and the output VSYNC with a programmable width in lines. The typical settings are 32 pixel steps and 4 lines. Each of the three outputs has its own polarity bit. When the filter is switched off, VSYNC is passed through with one pixel step of delay.

Top module: `sync_field_filter`

## Requirements
- R1: After reset every output is at its inactive level for the selected polarity, the field flag shows even, and the HSYNC count reads 0.
- R2: A pixel step on which `hs_in` goes from 0 to 1 makes the internal HSYNC pulse active from the next clock. The pulse lasts `hs_width` pixel steps. A new leading edge restarts the pulse. A width of 0 gives no pulse.
- R3: On cycles with `pix_en` low, no state changes and no output changes, except where a configuration input itself changes.
- R4: The line period is the number of pixel steps between the last two HSYNC leading edges. It is valid once it is at least 2. A VSYNC pulse is accepted on the pixel step where it has been high for a full line period. A shorter pulse is ignored: it does not pulse `vs_out`, change the field flag or latch the count.
- R5: With the filter enabled, `vs_out` becomes active one clock after the first mid-line step following an acceptance. A mid-line step is one whose position in the line equals half the line period, rounded down. `vs_out` stays active for `vs_width` lines, measured from mid-line to mid-line. A width of 0 gives no pulse.
- R6: Let p be the position of the VSYNC leading edge in its line (0 on the HSYNC leading-edge step) and L the line period. The field is even when L <= 4p < 3L, and odd otherwise. The flag takes the new value at acceptance. `field_out` at its active level means odd.
- R7: At acceptance, `hs_per_vs` takes the number of HSYNC leading edges since the previous acceptance, including one on the acceptance step itself, and the running count restarts. The count saturates at 4095.
- R8: With the filter disabled, `vs_out` follows `vs_in` delayed by one pixel step, the field flag is cleared to even, and `hs_per_vs` reads 0.
- R9: Each polarity bit set to 1 makes its output active high. Set to 0, the output is inverted.
- R10: With the filter enabled, `vs_out` never changes on the same clock as an `hs_out` leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel step enable |
| hs_in | input | 1 | Incoming HSYNC, active high |
| vs_in | input | 1 | Incoming VSYNC, active high |
| filt_en | input | 1 | Filter enable |
| hs_width | input | 8 | Output HSYNC width in pixel steps |
| vs_width | input | 8 | Output VSYNC width in lines |
| hs_pol | input | 1 | 1: hs_out active high |
| vs_pol | input | 1 | 1: vs_out active high |
| fld_pol | input | 1 | 1: field_out high means odd |
| hs_out | output | 1 | Regenerated HSYNC |
| vs_out | output | 1 | Re-timed or passed-through VSYNC |
| field_out | output | 1 | Odd/even field flag |
| hs_per_vs | output | 12 | HSYNC leading edges per accepted VSYNC |

## Verification
The hardest cases to reach from the ports are a VSYNC leading edge that lands exactly on a quadrant boundary, and a pulse that is a few pixels short of a full line. Both depend on the alignment between the VSYNC edge and the measured line period. The stimulus builds every frame from a line-locked generator that places the VSYNC rise at a chosen pixel offset and holds it for a chosen number of pixel steps. This puts edges on each side of the 4p = L and 4p = 3L boundaries and sends a pulse five steps short of a line. One run repeats this with pixel-enable gaps, so that line timing counts steps and not clocks.

// File: rtl/sff_pkg.sv
`timescale 1ns/1ps
// Shared types for the sync filter: line quadrant encoding and field rule.
package sff_pkg;

    typedef enum logic [1:0] {
        Q_FIRST  = 2'd0,
        Q_SECOND = 2'd1,
        Q_THIRD  = 2'd2,
        Q_FOURTH = 2'd3
    } quad_e;

    // Outer quadrants give an odd field, inner ones an even field.
    function automatic logic quad_is_odd(input quad_e q);
        return (q == Q_FIRST) || (q == Q_FOURTH);
    endfunction

endpackage

// File: rtl/sff_line_timer.sv
`timescale 1ns/1ps
// Line timer: detects sync leading edges on pixel steps, tracks the pixel
// position within the line and measures the line period.
// Assumes hs_in and vs_in are already synchronous to clk and active high.
module sff_line_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             hs_in,
    input  logic             vs_in,
    output logic             hs_rise,
    output logic             vs_rise,
    output logic [CNT_W-1:0] cur_pos,
    output logic [CNT_W-1:0] line_len,
    output logic             line_ok,
    output logic             mid_hit,
    output logic             vs_dly
);
    localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LEN_MIN = CNT_W'(2);

    logic             hs_q;
    logic             vs_q;
    logic             seen_hs;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] pos_inc;
    logic             hs_edge;

    // Edge detection and position of the current sample
    always_comb begin
        hs_edge = hs_in & ~hs_q;
        pos_inc = (pos == POS_MAX) ? pos : pos + 1'b1;
        cur_pos = hs_edge ? '0 : pos_inc;
        hs_rise = pix_en & hs_edge;
        vs_rise = pix_en & vs_in & ~vs_q;
        line_ok = (line_len >= LEN_MIN);
        mid_hit = pix_en & line_ok & (cur_pos == (line_len >> 1));
        vs_dly  = vs_q;
    end

    // Sync history, position counter and line period register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q     <= 1'b0;
            vs_q     <= 1'b0;
            seen_hs  <= 1'b0;
            pos      <= '0;
            line_len <= '0;
        end else if (pix_en) begin
            hs_q <= hs_in;
            vs_q <= vs_in;
            if (hs_edge) begin
                pos     <= '0;
                seen_hs <= 1'b1;
                if (seen_hs) begin
                    line_len <= pos_inc;
                end
            end else begin
                pos <= pos_inc;
            end
        end
    end

endmodule

// File: rtl/sff_hs_shaper.sv
`timescale 1ns/1ps
// HSYNC shaper: regenerates HSYNC as a pulse of programmable width in
// pixel steps, restarted by every incoming leading edge.
module sff_hs_shaper #(
    parameter int HW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pix_en,
    input  logic            hs_rise,
    input  logic [HW_W-1:0] hs_width,
    output logic            hs_act
);
    logic [HW_W-1:0] left;

    // Pulse start on leading edge, count down remaining steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_act <= 1'b0;
            left   <= '0;
        end else if (pix_en) begin
            if (hs_rise) begin
                hs_act <= (hs_width != '0);
                left   <= (hs_width != '0) ? hs_width - 1'b1 : '0;
            end else if (hs_act) begin
                if (left == '0) begin
                    hs_act <= 1'b0;
                end else begin
                    left <= left - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sff_vs_qualify.sv
`timescale 1ns/1ps
// VSYNC qualifier: accepts a VSYNC pulse once it has lasted a full line,
// decides the field from the quadrant of its leading edge and latches the
// HSYNC count. Assumes a valid line period before acceptance is possible.
module sff_vs_qualify
    import sff_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int HCNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              filt_en,
    input  logic              vs_in,
    input  logic              hs_rise,
    input  logic              vs_rise,
    input  logic [CNT_W-1:0]  cur_pos,
    input  logic [CNT_W-1:0]  line_len,
    input  logic              line_ok,
    output logic              accept,
    output logic              fld_odd,
    output logic [HCNT_W-1:0] hs_per_vs
);
    localparam int               QW      = CNT_W + 2;
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};
    localparam logic [HCNT_W-1:0] HC_MAX = {HCNT_W{1'b1}};

    logic              armed;
    logic              pend_odd;
    logic [CNT_W-1:0]  vrun;
    logic [CNT_W-1:0]  run_incl;
    logic [HCNT_W-1:0] hcnt;
    logic [HCNT_W-1:0] hcnt_inc;
    logic [QW-1:0]     four_pos;
    logic [QW-1:0]     len1;
    logic [QW-1:0]     len2;
    logic [QW-1:0]     len3;
    quad_e             quad;

    // Quadrant of the current position within the measured line
    always_comb begin
        four_pos = {cur_pos, 2'b00};
        len1     = {2'b00, line_len};
        len2     = len1 << 1;
        len3     = len1 + len2;
        if (four_pos < len1)      quad = Q_FIRST;
        else if (four_pos < len2) quad = Q_SECOND;
        else if (four_pos < len3) quad = Q_THIRD;
        else                      quad = Q_FOURTH;
    end

    // Pulse length including this step, HSYNC count including this step
    always_comb begin
        run_incl = vs_rise ? CNT_W'(1) : ((vrun == RUN_MAX) ? vrun : vrun + 1'b1);
        hcnt_inc = (hs_rise && hcnt != HC_MAX) ? hcnt + 1'b1 : hcnt;
        accept   = pix_en & filt_en & vs_in & armed & line_ok & (run_incl >= line_len);
    end

    // Pulse tracking, field decision and count latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            pend_odd  <= 1'b0;
            vrun      <= '0;
            fld_odd   <= 1'b0;
            hcnt      <= '0;
            hs_per_vs <= '0;
        end else if (!filt_en) begin
            armed     <= 1'b0;
            vrun      <= '0;
            fld_odd   <= 1'b0;
            hcnt      <= '0;
            hs_per_vs <= '0;
        end else if (pix_en) begin
            if (!vs_in)       armed <= 1'b0;
            else if (accept)  armed <= 1'b0;
            else if (vs_rise) armed <= 1'b1;
            vrun <= vs_in ? run_incl : '0;
            if (vs_rise) begin
                pend_odd <= quad_is_odd(quad);
            end
            if (accept) begin
                fld_odd   <= pend_odd;
                hs_per_vs <= hcnt_inc;
                hcnt      <= '0;
            end else begin
                hcnt <= hcnt_inc;
            end
        end
    end

endmodule

// File: rtl/sff_vs_shaper.sv
`timescale 1ns/1ps
// VSYNC shaper: starts the output pulse at the mid-line step after an
// acceptance and ends it a programmed number of mid-line steps later.
module sff_vs_shaper #(
    parameter int VW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pix_en,
    input  logic            filt_en,
    input  logic            accept,
    input  logic            mid_hit,
    input  logic [VW_W-1:0] vs_width,
    output logic            vs_act
);
    logic            pend;
    logic [VW_W-1:0] left;
    logic            start;

    // A waiting pulse starts only at a mid-line step while idle
    always_comb begin
        start = mid_hit & ~vs_act & pend;
    end

    // Pending flag, active flag and remaining line count
    always_ff @(posedge clk) begin
        if (!rst_n || !filt_en) begin
            pend   <= 1'b0;
            vs_act <= 1'b0;
            left   <= '0;
        end else if (pix_en) begin
            if (accept)     pend <= 1'b1;
            else if (start) pend <= 1'b0;
            if (mid_hit && vs_act) begin
                if (left == VW_W'(1)) vs_act <= 1'b0;
                left <= left - 1'b1;
            end else if (start && vs_width != '0) begin
                vs_act <= 1'b1;
                left   <= vs_width;
            end
        end
    end

endmodule

// File: rtl/sync_field_filter.sv
`timescale 1ns/1ps
// Sync field filter top: ties the line timer, HSYNC shaper, VSYNC
// qualifier and VSYNC shaper together and applies output polarities.
// Assumes all inputs are synchronous to clk.
module sync_field_filter #(
    parameter int CNT_W  = 12,
    parameter int HCNT_W = 12,
    parameter int HW_W   = 8,
    parameter int VW_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              hs_in,
    input  logic              vs_in,
    input  logic              filt_en,
    input  logic [HW_W-1:0]   hs_width,
    input  logic [VW_W-1:0]   vs_width,
    input  logic              hs_pol,
    input  logic              vs_pol,
    input  logic              fld_pol,
    output logic              hs_out,
    output logic              vs_out,
    output logic              field_out,
    output logic [HCNT_W-1:0] hs_per_vs
);
    logic             hs_rise_w;
    logic             vs_rise_w;
    logic [CNT_W-1:0] cur_pos_w;
    logic [CNT_W-1:0] line_len_w;
    logic             line_ok_w;
    logic             mid_w;
    logic             vs_dly_w;
    logic             hs_act_w;
    logic             acc_w;
    logic             fld_w;
    logic             vs_act_w;
    logic             vs_raw;

    sff_line_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .hs_in(hs_in), .vs_in(vs_in),
        .hs_rise(hs_rise_w), .vs_rise(vs_rise_w),
        .cur_pos(cur_pos_w), .line_len(line_len_w), .line_ok(line_ok_w),
        .mid_hit(mid_w), .vs_dly(vs_dly_w)
    );

    sff_hs_shaper #(.HW_W(HW_W)) u_hs (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .hs_rise(hs_rise_w), .hs_width(hs_width), .hs_act(hs_act_w)
    );

    sff_vs_qualify #(.CNT_W(CNT_W), .HCNT_W(HCNT_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .filt_en(filt_en),
        .vs_in(vs_in), .hs_rise(hs_rise_w), .vs_rise(vs_rise_w),
        .cur_pos(cur_pos_w), .line_len(line_len_w), .line_ok(line_ok_w),
        .accept(acc_w), .fld_odd(fld_w), .hs_per_vs(hs_per_vs)
    );

    sff_vs_shaper #(.VW_W(VW_W)) u_vs (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .filt_en(filt_en),
        .accept(acc_w), .mid_hit(mid_w), .vs_width(vs_width),
        .vs_act(vs_act_w)
    );

    // Output source selection and polarity
    always_comb begin
        vs_raw    = filt_en ? vs_act_w : vs_dly_w;
        hs_out    = hs_pol  ? hs_act_w : ~hs_act_w;
        vs_out    = vs_pol  ? vs_raw   : ~vs_raw;
        field_out = fld_pol ? fld_w    : ~fld_w;
    end

endmodule

// File: rtl/sff_checker.sv
`timescale 1ns/1ps
// Property checker for sync_field_filter, attached by bind.
module sff_checker #(
    parameter int HW_W   = 8,
    parameter int HCNT_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_en,
    input logic              filt_en,
    input logic [HW_W-1:0]   hs_width,
    input logic              hs_rise,
    input logic              hs_act,
    input logic              vs_act,
    input logic              mid_hit,
    input logic              accept,
    input logic              fld_odd,
    input logic [HCNT_W-1:0] hs_per_vs
);
    // R2: a leading edge with nonzero width starts the HSYNC pulse
    a_r2_hs_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_rise && hs_width != '0) |=> hs_act);

    // R3: nothing moves without a pixel step
    a_r3_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en && filt_en) |=> ($stable(hs_act) && $stable(vs_act) && $stable(hs_per_vs)));

    // R4: the field flag only moves on acceptance
    a_r4_field_moves_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(filt_en) && !$past(accept)) |-> $stable(fld_odd));

    // R5: the re-timed VSYNC starts only from a mid-line step
    a_r5_vs_starts_midline: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_act) |-> $past(mid_hit));

    // R8: count reads zero with the filter off
    a_r8_count_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en |=> (hs_per_vs == '0));

    // R10: VSYNC stays put when HSYNC starts
    a_r10_vs_clear_of_hs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(filt_en) && $rose(hs_act)) |-> $stable(vs_act));

endmodule

bind sync_field_filter sff_checker #(.HW_W(HW_W), .HCNT_W(HCNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .filt_en(filt_en),
    .hs_width(hs_width), .hs_rise(hs_rise_w), .hs_act(hs_act_w),
    .vs_act(vs_act_w), .mid_hit(mid_w), .accept(acc_w),
    .fld_odd(fld_w), .hs_per_vs(hs_per_vs)
);

// File: tb/tb_sync_field_filter.sv
`timescale 1ns/1ps
module tb_sync_field_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0, pix_en = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
    logic filt_en = 1'b1, hs_pol = 1'b1, vs_pol = 1'b1, fld_pol = 1'b1;
    logic [7:0] hs_width = 8'd32, vs_width = 8'd4;
    logic hs_out, vs_out, field_out;
    logic [11:0] hs_per_vs;

    always #4 clk = ~clk;

    sync_field_filter dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hs_in(hs_in), .vs_in(vs_in),
        .filt_en(filt_en), .hs_width(hs_width), .vs_width(vs_width),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .fld_pol(fld_pol),
        .hs_out(hs_out), .vs_out(vs_out), .field_out(field_out), .hs_per_vs(hs_per_vs)
    );

    int checks = 0, failures = 0;
    bit cmp_on = 0, gaps = 0;
    int pxn = 0;

    // reference model state, indexed by pixel step number
    int k, last_hs, lper, vrk, mleft, hstart, hw, cnt, hc, hinc, cur;
    bit seen, hp, vp, vdly, varm, podd, fld, mpend, mact, ehs, last_pe;
    bit hr, vr, mid, acc, start;
    // monitors
    bit prev_hs, prev_vs, prev_fd; int prev_cnt;
    int r3_bad = 0, r10_bad = 0, r10_seen = 0, vs_rises = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model of the requirements, one update per clock
    always @(posedge clk) begin
        last_pe = pix_en;
        if (!rst_n) begin
            k = 0; last_hs = -1; seen = 0; lper = 0; hp = 0; vp = 0; vdly = 0;
            varm = 0; vrk = 0; podd = 0; fld = 0; hc = 0; cnt = 0;
            mpend = 0; mact = 0; mleft = 0; hstart = -1; hw = 0; ehs = 0;
        end else begin
            if (!filt_en) begin
                varm = 0; fld = 0; hc = 0; cnt = 0; mpend = 0; mact = 0; mleft = 0;
            end
            if (pix_en) begin
                hr = hs_in && !hp;
                vr = vs_in && !vp;
                cur = hr ? 0 : k - last_hs;
                mid = (lper >= 2) && (cur == lper / 2);
                if (filt_en) begin
                    acc = vs_in && varm && (lper >= 2) && (k - vrk + 1 >= lper);
                    start = mid && !mact && mpend;
                    if (mid && mact) begin
                        if (mleft == 1) mact = 0;
                        mleft--;
                    end else if (start && vs_width != 0) begin
                        mact = 1; mleft = vs_width;
                    end
                    if (acc) mpend = 1; else if (start) mpend = 0;
                    hinc = hc + (hr ? 1 : 0);
                    if (hinc > 4095) hinc = 4095;
                    if (acc) begin fld = podd; cnt = hinc; hc = 0; end
                    else hc = hinc;
                    if (vr) podd = (4 * cur < lper) || (4 * cur >= 3 * lper);
                    if (!vs_in) varm = 0;
                    else if (acc) varm = 0;
                    else if (vr) begin varm = 1; vrk = k; end
                end
                if (hr) begin
                    hstart = k; hw = hs_width;
                    if (seen) lper = k - last_hs;
                    seen = 1; last_hs = k;
                end
                ehs = (hstart >= 0) && (k >= hstart) && (k < hstart + hw);
                hp = hs_in; vp = vs_in; vdly = vs_in;
                k++;
            end
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        bit evs;
        if (rst_n && cmp_on) begin
            evs = filt_en ? mact : vdly;
            chk("R2", hs_out, hs_pol ? ehs : !ehs);
            chk(filt_en ? "R5" : "R8", vs_out, vs_pol ? evs : !evs);
            chk("R6", field_out, fld_pol ? fld : !fld);
            chk("R7", hs_per_vs, cnt);
            if (!last_pe && (hs_out != prev_hs || vs_out != prev_vs ||
                             field_out != prev_fd || hs_per_vs != prev_cnt)) r3_bad++;
            if (filt_en && hs_out == hs_pol && prev_hs != hs_pol) begin
                r10_seen++;
                if (vs_out != prev_vs) r10_bad++;
            end
            if (vs_out == vs_pol && prev_vs != vs_pol) vs_rises++;
        end
        prev_hs = hs_out; prev_vs = vs_out; prev_fd = field_out; prev_cnt = hs_per_vs;
    end

    task automatic px(bit h, bit v);
        if (gaps && (pxn % 5) == 4) begin
            @(posedge clk); #2; pix_en = 0; hs_in = h; vs_in = v;
        end
        @(posedge clk); #2; pix_en = 1; hs_in = h; vs_in = v;
        pxn++;
    endtask

    // one frame of nl lines of L steps, VSYNC from (vl, voff) for vlen steps
    task automatic frame(int L, int nl, int vl, int voff, int vlen);
        for (int ln = 0; ln < nl; ln++) begin
            for (int p = 0; p < L; p++) begin
                int g = ln * L + p;
                int s = vl * L + voff;
                px(p < 3, (g >= s) && (g < s + vlen));
            end
        end
    endtask

    task automatic do_reset();
        cmp_on = 0;
        @(posedge clk); #2; rst_n = 0; pix_en = 0; hs_in = 0; vs_in = 0;
        repeat (3) @(posedge clk);
        #2; rst_n = 1;
        @(negedge clk);
        cmp_on = 1;
    endtask

    initial begin
        int snap_cnt, snap_rises;
        // phase A: defaults, field quadrants including exact boundaries
        do_reset();
        chk("R1", hs_out, 0); chk("R1", vs_out, 0);
        chk("R1", field_out, 0); chk("R1", hs_per_vs, 0);
        snap_rises = vs_rises;
        frame(40, 12, 3, 2, 80);
        @(negedge clk); chk("R6", field_out, 1);
        frame(40, 12, 3, 10, 80);
        @(negedge clk); chk("R6", field_out, 0);
        chk("R7", hs_per_vs, 12);
        frame(40, 12, 3, 9, 80);
        @(negedge clk); chk("R6", field_out, 1);
        frame(40, 12, 3, 25, 80);
        @(negedge clk); chk("R6", field_out, 0);
        frame(40, 12, 3, 29, 80);
        @(negedge clk); chk("R6", field_out, 0);
        frame(40, 12, 3, 30, 80);
        @(negedge clk); chk("R6", field_out, 1);
        chk("R5", vs_rises - snap_rises, 6);
        // phase B: spurious short pulse is ignored
        snap_cnt = hs_per_vs; snap_rises = vs_rises;
        frame(40, 12, 3, 12, 35);
        @(negedge clk);
        chk("R4", vs_rises - snap_rises, 0);
        chk("R4", hs_per_vs, snap_cnt);
        chk("R4", field_out, 1);
        frame(40, 12, 3, 12, 80);
        @(negedge clk); chk("R4", hs_per_vs, 24); chk("R6", field_out, 0);
        // phase C: inverted polarities, short widths, pixel-enable gaps
        hs_pol = 0; vs_pol = 0; fld_pol = 0; hs_width = 8'd5; vs_width = 8'd1;
        do_reset();
        chk("R9", hs_out, 1); chk("R9", vs_out, 1); chk("R9", field_out, 1);
        gaps = 1;
        frame(24, 10, 2, 20, 50);
        frame(24, 10, 2, 7, 50);
        @(negedge clk); chk("R9", field_out, 1);
        gaps = 0;
        chk("R3", r3_bad, 0);
        // phase D: filter off passes VSYNC through
        hs_pol = 1; vs_pol = 1; fld_pol = 1; hs_width = 8'd32; vs_width = 8'd4;
        filt_en = 0;
        do_reset();
        frame(40, 8, 3, 12, 80);
        @(negedge clk); chk("R8", hs_per_vs, 0); chk("R8", field_out, 0);
        // phase E: zero widths suppress pulses
        filt_en = 1; hs_width = 8'd0; vs_width = 8'd0;
        do_reset();
        snap_rises = vs_rises;
        frame(40, 12, 3, 12, 80);
        @(negedge clk);
        chk("R5", vs_rises - snap_rises, 0); chk("R2", hs_out, 0);
        chk("R10", r10_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule